// File: doc/BRIEF.md
# Halfword Jump-Table Branch Sequencer

This block carries out a table-driven branch as a fixed multi-cycle sequence. The table of signed 16-bit offsets sits directly after the two-byte branch instruction, so its base is the address of the following instruction (PC+2). An index register picks one entry. The sequencer forms the entry's byte address and fetches that halfword over a simple request/acknowledge read port. The new program counter is the same base plus the entry, sign-extended and doubled.

The core pulses `start` with the current PC and the index value. It then waits for `done`. In the cycle where `done` is high, `next_pc` holds the branch target. Fetching instructions is left to the surrounding core.

Top module: `jt_branch_seq`

## Requirements
- R1: After synchronous reset, `done` and `mem_req` are both 0.
- R2: While `mem_req` is high, `mem_addr` equals B + 2·index modulo 2^32. B is the base: `cur_pc` with bit 0 forced to 0, plus 2. Bit 0 of `mem_addr` is therefore 0.
- R3: `mem_req` rises in the second cycle after the cycle that samples `start`. It keeps `mem_addr` unchanged until a cycle with `mem_ack` high, and falls in the next cycle.
- R4: `next_pc` equals B plus the 16-bit `mem_rdata` captured with the acknowledge, sign-extended to 32 bits and shifted left by one, modulo 2^32.
- R5: With `mem_ack` high in the first request cycle, `done` is high 5 cycles after the cycle that samples `start`. Each cycle the acknowledge is held back adds one cycle.
- R6: `done` stays high for exactly one cycle per operation.
- R7: Bit 0 of `next_pc` is 0 when `done` is high, even when `cur_pc` is odd.
- R8: A `start` pulse that arrives while an operation is in progress has no effect. The running operation's address and target are unchanged, and no second operation follows.
- R9: Each operation makes exactly one acknowledged read, and `mem_req` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| cur_pc | input | 32 | Address of the branch instruction |
| index_val | input | 32 | Table index register value |
| mem_req | output | 1 | Halfword read request |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_ack | input | 1 | Read data valid; ends the request |
| mem_rdata | input | 16 | Table entry returned with `mem_ack` |
| done | output | 1 | One-cycle completion strobe |
| next_pc | output | 32 | Branch target, valid while `done` is high |

## Verification
The hardest cases to reach are a second `start` that lands while a read is stalled, and acknowledges that come late by different amounts. The bench's memory model holds back the acknowledge for a chosen number of cycles (zero, one, three, and random amounts). Some operations raise `start` again mid-flight with a different PC. The bench then confirms that the target comes from the first PC and that no extra read or `done` follows. Directed cases cover the most negative and most positive entries, an index that wraps the address space, and an odd PC.

// File: rtl/jt_pkg.sv
package jt_pkg;

    localparam int PC_W      = 32;
    localparam int ENT_W     = 16;
    localparam int INSN_SIZE = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_EXT,
        ST_SUM,
        ST_DONE
    } jt_state_e;

    typedef struct packed {
        logic ld_base;
        logic ld_addr;
        logic ld_ent;
        logic ld_ofs;
        logic ld_tgt;
    } jt_ctl_t;

endpackage

// File: rtl/jt_ctrl.sv
module jt_ctrl
    import jt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    mem_ack,
    output jt_ctl_t ctl,
    output logic    mem_req,
    output logic    done
);

    jt_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ADDR;
            ST_ADDR: st_d = ST_READ;
            ST_READ: if (mem_ack) st_d = ST_EXT;
            ST_EXT:  st_d = ST_SUM;
            ST_SUM:  st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl         = '0;
        ctl.ld_base = (st_q == ST_IDLE) && start;
        ctl.ld_addr = (st_q == ST_ADDR);
        ctl.ld_ent  = (st_q == ST_READ) && mem_ack;
        ctl.ld_ofs  = (st_q == ST_EXT);
        ctl.ld_tgt  = (st_q == ST_SUM);
    end

    assign mem_req = (st_q == ST_READ);
    assign done    = (st_q == ST_DONE);

endmodule

// File: rtl/jt_dp.sv
module jt_dp
    import jt_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int EW = ENT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  jt_ctl_t       ctl,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] idx,
    input  logic [EW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] target
);

    localparam logic [AW-1:0] STEP = AW'(INSN_SIZE);
    localparam int            PAD  = AW - EW;

    logic [AW-1:0] base_q, idx_q, addr_q, ofs_q, tgt_q;
    logic [EW-1:0] ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            idx_q  <= '0;
            addr_q <= '0;
            ent_q  <= '0;
            ofs_q  <= '0;
            tgt_q  <= '0;
        end else begin
            if (ctl.ld_base) begin
                base_q <= ((pc >> 1) << 1) + STEP;
                idx_q  <= idx;
            end
            if (ctl.ld_addr) addr_q <= base_q + (idx_q << 1);
            if (ctl.ld_ent)  ent_q  <= rdata;
            if (ctl.ld_ofs)  ofs_q  <= {{PAD{ent_q[EW-1]}}, ent_q} << 1;
            if (ctl.ld_tgt)  tgt_q  <= base_q + ofs_q;
        end
    end

    assign addr   = addr_q;
    assign target = tgt_q;

endmodule

// File: rtl/jt_branch_seq.sv
module jt_branch_seq
    import jt_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int EW = ENT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] index_val,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [EW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] next_pc
);

    jt_ctl_t ctl;

    jt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mem_ack (mem_ack),
        .ctl     (ctl),
        .mem_req (mem_req),
        .done    (done)
    );

    jt_dp #(.AW(AW), .EW(EW)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .pc     (cur_pc),
        .idx    (index_val),
        .rdata  (mem_rdata),
        .addr   (mem_addr),
        .target (next_pc)
    );

endmodule

// File: rtl/jt_branch_seq_chk.sv
module jt_branch_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          pc_lsb
);

    // R3: address held while the request waits
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R3: request withdrawn after acknowledge
    p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req);

    // R2: table address is halfword aligned
    p_addr_even_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]);

    // R6: completion strobe lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: target is even
    p_pc_even_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !pc_lsb);

    // R9: no read outstanding at completion
    p_no_req_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

endmodule

bind jt_branch_seq jt_branch_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .done     (done),
    .pc_lsb   (next_pc[0])
);

// File: tb/jt_branch_seq_bench.sv
`timescale 1ns/1ps
module jt_branch_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] index_val = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic [31:0] next_pc;

    int total = 0;
    int bad   = 0;

    // memory model state
    logic [15:0] hw_v = '0;
    int          wait_n = 0;
    int          wcnt = 0;
    int          nreq = 0;
    int          addr_moves = 0;
    logic [31:0] seen_addr = '0;
    logic [31:0] held_addr = '0;

    always #4 clk = ~clk;

    jt_branch_seq u_jt_branch_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cur_pc    (cur_pc),
        .index_val (index_val),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (done),
        .next_pc   (next_pc)
    );

    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt == 0) held_addr = mem_addr;
            else if (mem_addr != held_addr) addr_moves++;
            if (wcnt == wait_n) begin
                mem_ack   = 1'b1;
                mem_rdata = hw_v;
                seen_addr = mem_addr;
                nreq++;
                wcnt = 0;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack   = 1'b0;
            mem_rdata = '0;
            wcnt      = 0;
        end
    end

    function automatic logic [31:0] f_base(input logic [31:0] pc);
        return {pc[31:1], 1'b0} + 32'd2;
    endfunction

    function automatic logic [31:0] f_addr(input logic [31:0] pc, input logic [31:0] idx);
        return f_base(pc) + {idx[30:0], 1'b0};
    endfunction

    function automatic logic [31:0] f_tgt(input logic [31:0] pc, input logic [15:0] hw);
        logic [31:0] s;
        s = {{16{hw[15]}}, hw};
        return f_base(pc) + {s[30:0], 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] pc, input logic [31:0] idx,
                          input logic [15:0] hw, input int w, input bit inj);
        int cyc;
        int extra;
        hw_v = hw;
        wait_n = w;
        nreq = 0;
        addr_moves = 0;
        @(negedge clk);
        start = 1'b1;
        cur_pc = pc;
        index_val = idx;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 64) begin
            if (cyc == 2) chk(mem_req == 1'b1, "R3 req start", 32'(mem_req), 32'd1);
            if (inj && cyc == 2) begin
                start = 1'b1;
                cur_pc = ~pc;
                index_val = idx + 32'd7;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == 5 + w, "R5 latency", 32'(cyc), 32'(5 + w));
        chk(seen_addr == f_addr(pc, idx), "R2 addr", seen_addr, f_addr(pc, idx));
        chk(next_pc == f_tgt(pc, hw), inj ? "R8 target" : "R4 target", next_pc, f_tgt(pc, hw));
        chk(next_pc[0] == 1'b0, "R7 lsb", 32'(next_pc[0]), 32'd0);
        chk(mem_req == 1'b0, "R9 req at done", 32'(mem_req), 32'd0);
        chk(addr_moves == 0, "R3 addr hold", 32'(addr_moves), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R6 pulse", 32'(done), 32'd0);
        if (inj) begin
            extra = 0;
            repeat (8) begin
                @(negedge clk);
                if (done || mem_req) extra++;
            end
            chk(extra == 0, "R8 no extra op", 32'(extra), 32'd0);
        end
        chk(nreq == 1, "R9 one read", 32'(nreq), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
        chk(mem_req == 1'b0, "R1 req", 32'(mem_req), 32'd0);

        run_op(32'h0000_1000, 32'd0, 16'h0000, 0, 1'b0);
        run_op(32'h0000_2000, 32'd3, 16'h8000, 0, 1'b0);
        run_op(32'h0000_3000, 32'd5, 16'h7FFF, 1, 1'b0);
        run_op(32'h0000_4000, 32'hFFFF_FFFF, 16'hFFFF, 3, 1'b0);
        run_op(32'h0000_5001, 32'd2, 16'h0011, 0, 1'b0);
        run_op(32'hFFFF_FFFE, 32'd1, 16'h0004, 2, 1'b0);
        run_op(32'h0001_0000, 32'd9, 16'h1234, 3, 1'b1);
        run_op(32'h0002_0000, 32'd4, 16'hF00D, 0, 1'b1);

        for (int i = 0; i < 40; i++) begin
            run_op($urandom, $urandom, 16'($urandom), int'($urandom % 5), ($urandom % 4) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule